// File: doc/BRIEF.md
# Dual-slope conversion sequencer

This block is the digital controller of an integrating converter that works by two slopes. A prescaler divides the input clock into count ticks. A state machine with three phases steps through each conversion in a fixed order. First the integrator charges from the unknown signal for a fixed number of counts. It then discharges against the reference until the comparator reports a zero crossing. The rest of the fixed-length cycle is spent nulling offsets. The three registered, one-hot phase outputs drive the analog switch drivers.

During discharge a chain of BCD decades counts the ticks. When the comparator fires, the count is captured into an output register and shown on active-high seven-segment patterns. A conversion that never crosses zero is flagged as out of range. Auto-zero absorbs whatever discharge time the conversion did not use, so one conversion takes the same number of clocks whatever the input.

States are `PH_INT` (integrate), `PH_DEINT` (de-integrate) and `PH_AZ` (auto-zero). The transitions are:
- `T_START`: from `PH_AZ` to `PH_INT`, on the last count of the cycle.
- `T_RUNDOWN`: from `PH_INT` to `PH_DEINT`, after `INT_CNT` counts.
- `T_CROSS`: from `PH_DEINT` to `PH_AZ`, on the synchronised comparator.
- `T_OVER`: from `PH_DEINT` to `PH_AZ`, when the discharge window runs out.

Top module: `dsadc_seq`

## Requirements
- R1: A count tick occurs once every `CLK_DIV` input clocks. The phase outputs change only on the clock edge at which a tick occurs.
- R2: `ph_int` stays high for exactly `INT_CNT` counts (`INT_CNT*CLK_DIV` clocks) in every cycle.
- R3: `comp_in` passes through two flip-flops before it is used. De-integrate ends on the first tick in `PH_DEINT` at which the synchronised comparator is high. The reading latched at that tick is the number of de-integrate ticks that came before it. If `comp_in` rises just after the edge that ends the Nth de-integrate count, the reading is N.
- R4: If no crossing is seen within `DEINT_MAX` counts, the block enters `PH_AZ`, sets `over_range` to 1 and latches all nines (`16'h9999` with four digits). A valid reading clears `over_range`.
- R5: Auto-zero fills the rest of the cycle. From one rise of `ph_int` to the next there are always `CYCLE_CNT*CLK_DIV` clocks.
- R6: Exactly one phase output is high at any time. The phases always run in the order integrate, de-integrate, auto-zero, integrate.
- R7: While synchronous reset `rst` is high, the block holds `PH_AZ`, clears the decades, the digits and `over_range`, and keeps `cycle_done` low. After reset is released, the first auto-zero lasts `CYCLE_CNT-INT_CNT-DEINT_MAX` counts.
- R8: `cycle_done` goes high on the edge at which `ph_int` rises and stays high for exactly `CLK_DIV` clocks.
- R9: `digits` is packed BCD with units in bits [3:0], tens in [7:4], and so on. It changes only on the edge that enters `PH_AZ` and holds through the rest of the cycle.
- R10: For each digit, `segs[7*i +: 7]` is the pattern {g,f,e,d,c,b,a}, active high. The codes for 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R11: A high comparator during integrate or auto-zero has no effect on phase timing or on the reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous reset, active high |
| comp_in | input | 1 | Comparator zero-crossing indication, asynchronous |
| ph_int | output | 1 | Integrate switch strobe |
| ph_deint | output | 1 | De-integrate switch strobe |
| ph_az | output | 1 | Auto-zero switch strobe |
| cycle_done | output | 1 | Cycle boundary pulse, `CLK_DIV` clocks wide |
| over_range | output | 1 | Last conversion ran out of de-integrate window |
| digits | output | 4*DIGITS | Latched BCD reading |
| segs | output | 7*DIGITS | Seven-segment patterns of the latched digits |

## Verification
The hardest case to reach is a comparator edge that lands in the last de-integrate count. There, the crossing and the window end compete at the same tick, and the two-stage synchroniser and the prescaler phase decide which one wins. The bench uses a small configuration and sweeps the comparator's rise point across every de-integrate count, from the first to beyond the window. Each rise is placed just after the edge that closes count N, so the last-count collision and the timeout are both hit on purpose. One extra cycle drives comparator pulses inside integrate and auto-zero to show that they are ignored.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    typedef enum logic [2:0] {
        PH_INT   = 3'b001,
        PH_DEINT = 3'b010,
        PH_AZ    = 3'b100
    } phase_e;

    // Active-high segment pattern, bit order {g,f,e,d,c,b,a}; blank for non-decimal codes
    function automatic logic [6:0] seg_of(input logic [3:0] d);
        logic [6:0] s;
        unique case (d)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dsadc_prescale.sv
module dsadc_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pcnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            pcnt_q <= '0;
        else if (pcnt_q == LAST)
            pcnt_q <= '0;
        else
            pcnt_q <= pcnt_q + 1'b1;
    end

    assign tick = (pcnt_q == LAST);
endmodule

// File: rtl/dsadc_sync2.sv
module dsadc_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic d_sync
);
    logic meta_q, stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            stab_q <= 1'b0;
        end else begin
            meta_q <= d_async;
            stab_q <= meta_q;
        end
    end

    assign d_sync = stab_q;
endmodule

// File: rtl/dsadc_bcd_chain.sv
module dsadc_bcd_chain #(
    parameter int DIGITS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  inc,
    output logic [4*DIGITS-1:0]   value
);
    logic [DIGITS:0] carry;

    assign carry[0] = inc;

    for (genvar g = 0; g < DIGITS; g++) begin : g_decade
        logic [3:0] dec_q;

        assign carry[g+1] = carry[g] && (dec_q == 4'd9);

        always_ff @(posedge clk) begin
            if (rst || clr)
                dec_q <= 4'd0;
            else if (carry[g])
                dec_q <= (dec_q == 4'd9) ? 4'd0 : dec_q + 4'd1;
        end

        assign value[4*g +: 4] = dec_q;
    end
endmodule

// File: rtl/dsadc_seg_out.sv
module dsadc_seg_out #(
    parameter int DIGITS = 4
) (
    input  logic [4*DIGITS-1:0] bcd,
    output logic [7*DIGITS-1:0] segs
);
    import dsadc_pkg::*;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dec
        assign segs[7*g +: 7] = seg_of(bcd[4*g +: 4]);
    end
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq #(
    parameter int CLK_DIV   = 4,
    parameter int INT_CNT   = 1000,
    parameter int DEINT_MAX = 2000,
    parameter int CYCLE_CNT = 4000,
    parameter int DIGITS    = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  comp_in,
    output logic                  ph_int,
    output logic                  ph_deint,
    output logic                  ph_az,
    output logic                  cycle_done,
    output logic                  over_range,
    output logic [4*DIGITS-1:0]   digits,
    output logic [7*DIGITS-1:0]   segs
);
    import dsadc_pkg::*;

    localparam int CW = $clog2(CYCLE_CNT);
    localparam logic [CW-1:0] CYC_LAST  = CW'(CYCLE_CNT - 1);
    localparam logic [CW-1:0] INT_LAST  = CW'(INT_CNT - 1);
    localparam logic [CW-1:0] DE_LAST   = CW'(INT_CNT + DEINT_MAX - 1);
    localparam logic [CW-1:0] AZ_ENTRY  = CW'(INT_CNT + DEINT_MAX);
    localparam logic [4*DIGITS-1:0] ALL_NINES = {DIGITS{4'h9}};

    logic                cnt_tick;
    logic                comp_s;
    logic [4*DIGITS-1:0] bcd_cnt;

    phase_e        state_q, state_d;
    logic [CW-1:0] cyc_q;

    logic ev_start, ev_rundown, ev_cross, ev_over;
    logic bcd_inc;

    dsadc_prescale #(.DIV(CLK_DIV)) i_presc (
        .clk  (clk),
        .rst  (rst),
        .tick (cnt_tick)
    );

    dsadc_sync2 i_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (comp_in),
        .d_sync  (comp_s)
    );

    // Transition events, all qualified by the count tick
    always_comb begin
        ev_start   = 1'b0;
        ev_rundown = 1'b0;
        ev_cross   = 1'b0;
        ev_over    = 1'b0;
        bcd_inc    = 1'b0;
        state_d    = state_q;
        unique case (state_q)
            PH_AZ: begin
                if (cnt_tick && cyc_q == CYC_LAST) begin
                    ev_start = 1'b1;          // T_START
                    state_d  = PH_INT;
                end
            end
            PH_INT: begin
                if (cnt_tick && cyc_q == INT_LAST) begin
                    ev_rundown = 1'b1;        // T_RUNDOWN
                    state_d    = PH_DEINT;
                end
            end
            PH_DEINT: begin
                if (cnt_tick) begin
                    if (comp_s) begin
                        ev_cross = 1'b1;      // T_CROSS
                        state_d  = PH_AZ;
                    end else if (cyc_q == DE_LAST) begin
                        ev_over = 1'b1;       // T_OVER
                        state_d = PH_AZ;
                    end else begin
                        bcd_inc = 1'b1;
                    end
                end
            end
            default: state_d = PH_AZ;
        endcase
    end

    // State register and cycle position
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_AZ;
            cyc_q   <= AZ_ENTRY;
        end else begin
            state_q <= state_d;
            if (cnt_tick)
                cyc_q <= (cyc_q == CYC_LAST) ? '0 : cyc_q + 1'b1;
        end
    end

    dsadc_bcd_chain #(.DIGITS(DIGITS)) i_bcd (
        .clk   (clk),
        .rst   (rst),
        .clr   (ev_rundown),
        .inc   (bcd_inc),
        .value (bcd_cnt)
    );

    // Registered outputs: cycle pulse, reading latch, overrange flag
    logic [4*DIGITS-1:0] dig_q;
    logic                over_q;
    logic                done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dig_q  <= '0;
            over_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (cnt_tick)
                done_q <= ev_start;
            if (ev_cross) begin
                dig_q  <= bcd_cnt;
                over_q <= 1'b0;
            end else if (ev_over) begin
                dig_q  <= ALL_NINES;
                over_q <= 1'b1;
            end
        end
    end

    dsadc_seg_out #(.DIGITS(DIGITS)) i_seg (
        .bcd  (dig_q),
        .segs (segs)
    );

    assign ph_int     = state_q[0];
    assign ph_deint   = state_q[1];
    assign ph_az      = state_q[2];
    assign cycle_done = done_q;
    assign over_range = over_q;
    assign digits     = dig_q;
endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
    parameter int INT_CNT   = 1000,
    parameter int DEINT_MAX = 2000,
    parameter int DIGITS    = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                tick,
    input logic                ph_int,
    input logic                ph_deint,
    input logic                ph_az,
    input logic                cycle_done,
    input logic                over_range,
    input logic [4*DIGITS-1:0] digits
);
    localparam int TW = $clog2(INT_CNT + DEINT_MAX + 2);

    logic [TW-1:0] int_ticks, de_ticks;

    always_ff @(posedge clk) begin
        if (rst) begin
            int_ticks <= '0;
            de_ticks  <= '0;
        end else begin
            if (!ph_int)      int_ticks <= '0;
            else if (tick)    int_ticks <= int_ticks + 1'b1;
            if (!ph_deint)    de_ticks  <= '0;
            else if (tick)    de_ticks  <= de_ticks + 1'b1;
        end
    end

    p_boundary_r1: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable({ph_int, ph_deint, ph_az}));

    p_int_len_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(ph_int) |-> int_ticks == TW'(INT_CNT));

    p_deint_window_r4: assert property (@(posedge clk) disable iff (rst)
        de_ticks <= TW'(DEINT_MAX));

    p_over_nines_r4: assert property (@(posedge clk) disable iff (rst)
        over_range |-> digits == {DIGITS{4'h9}});

    p_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $countones({ph_int, ph_deint, ph_az}) == 1);

    p_order_de_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ph_deint) |-> $past(ph_int));

    p_order_az_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ph_az) |-> $past(ph_deint));

    p_order_int_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ph_int) |-> $past(ph_az));

    p_done_in_int_r8: assert property (@(posedge clk) disable iff (rst)
        cycle_done |-> ph_int);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(ph_az && !$past(ph_az)) |-> $stable(digits));
endmodule

bind dsadc_seq dsadc_seq_chk #(
    .INT_CNT   (INT_CNT),
    .DEINT_MAX (DEINT_MAX),
    .DIGITS    (DIGITS)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (cnt_tick),
    .ph_int     (ph_int),
    .ph_deint   (ph_deint),
    .ph_az      (ph_az),
    .cycle_done (cycle_done),
    .over_range (over_range),
    .digits     (digits)
);

// File: tb/test_dsadc_seq.sv
module test_dsadc_seq;
    localparam int DIV  = 4;
    localparam int NI   = 10;
    localparam int ND   = 20;
    localparam int NC   = 40;
    localparam int NDIG = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic               rst, comp;
    logic               ph_int, ph_deint, ph_az, cycle_done, over_range;
    logic [4*NDIG-1:0]  digits;
    logic [7*NDIG-1:0]  segs;

    dsadc_seq #(
        .CLK_DIV(DIV), .INT_CNT(NI), .DEINT_MAX(ND), .CYCLE_CNT(NC), .DIGITS(NDIG)
    ) i_dsadc_seq (
        .clk(clk), .rst(rst), .comp_in(comp),
        .ph_int(ph_int), .ph_deint(ph_deint), .ph_az(ph_az),
        .cycle_done(cycle_done), .over_range(over_range),
        .digits(digits), .segs(segs)
    );

    int  n_checks = 0;
    int  n_err    = 0;
    bit  finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    function automatic logic [4*NDIG-1:0] to_bcd(input int v);
        logic [4*NDIG-1:0] r;
        for (int i = 0; i < NDIG; i++) begin
            r[4*i +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    function automatic logic [6:0] seg_ref(input logic [3:0] d);
        case (d)
            4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
            4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
            4'd6: return 7'h7D;  4'd7: return 7'h07;  4'd8: return 7'h7F;
            4'd9: return 7'h6F;  default: return 7'h00;
        endcase
    endfunction

    function automatic logic [7*NDIG-1:0] segs_ref(input logic [4*NDIG-1:0] b);
        logic [7*NDIG-1:0] r;
        for (int i = 0; i < NDIG; i++) r[7*i +: 7] = seg_ref(b[4*i +: 4]);
        return r;
    endfunction

    task automatic check_reset();
        chk({ph_int, ph_deint, ph_az} == 3'b001, "R7", "reset phase {int,de,az}",
            {ph_int, ph_deint, ph_az}, 3'b001);
        chk(digits == '0 && over_range == 1'b0 && cycle_done == 1'b0, "R7",
            "reset digits/over/done", {digits, over_range, cycle_done}, 0);
        chk(segs == segs_ref('0), "R10", "reset segments", segs, segs_ref('0));
    endtask

    initial begin
        logic [4*NDIG-1:0] prev_dig;
        bit                prev_ovr;
        int                k;

        rst  = 1'b1;
        comp = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check_reset();
        rst = 1'b0;

        k = 0;
        while (!ph_int && k < 1000) begin
            @(posedge clk); @(negedge clk);
            k++;
        end
        chk(k == (NC - NI - ND) * DIV, "R7", "first auto-zero clocks", k, (NC - NI - ND) * DIV);

        prev_dig = '0;
        prev_ovr = 1'b0;

        for (int trial = 0; trial <= ND + 3; trial++) begin
            int  n      = (trial <= ND + 2) ? trial : 7;
            bit  noise  = (trial == ND + 3);
            bit  ovr    = (n >= ND);
            int  len    = ovr ? ND : n + 1;
            logic [4*NDIG-1:0] nv = ovr ? {NDIG{4'h9}} : to_bcd(n);
            int  bad_ph = 0, bad_done = 0, bad_dig = 0, bad_seg = 0;
            longint a_ph = 0, e_ph = 0, a_dig = 0, e_dig = 0;

            chk(ph_int && cycle_done, "R8", "cycle start pulse with integrate",
                {ph_int, cycle_done}, 2'b11);

            for (int t = 1; t <= NC * DIV; t++) begin
                int tt;
                bit e_int, e_de, e_az, e_done;
                logic [4*NDIG-1:0] edig;
                bit eovr;
                @(posedge clk); @(negedge clk);
                tt     = t % (NC * DIV);
                e_int  = tt < NI * DIV;
                e_de   = !e_int && tt < (NI + len) * DIV;
                e_az   = !e_int && !e_de;
                e_done = tt < DIV;
                edig   = (t >= (NI + len) * DIV) ? nv : prev_dig;
                eovr   = (t >= (NI + len) * DIV) ? ovr : prev_ovr;
                if ({ph_int, ph_deint, ph_az} != {e_int, e_de, e_az}) begin
                    if (bad_ph == 0) begin
                        a_ph = {ph_int, ph_deint, ph_az, 16'(t)};
                        e_ph = {e_int, e_de, e_az, 16'(t)};
                    end
                    bad_ph++;
                end
                if (cycle_done != e_done) bad_done++;
                if (digits != edig || over_range != eovr) begin
                    if (bad_dig == 0) begin
                        a_dig = {over_range, digits};
                        e_dig = {eovr, edig};
                    end
                    bad_dig++;
                end
                if (segs != segs_ref(edig)) bad_seg++;

                if (!ovr && t == (NI + n) * DIV) comp = 1'b1;
                if (t == (NI + len) * DIV)       comp = 1'b0;
                if (noise) begin
                    if (t == 2 * DIV)              comp = 1'b1;
                    if (t == (NI - 2) * DIV)       comp = 1'b0;
                    if (t == (NI + len + 2) * DIV) comp = 1'b1;
                    if (t == (NC - 2) * DIV)       comp = 1'b0;
                end
            end

            if (noise) begin
                chk(bad_ph == 0, "R11", "phase timing with comparator noise", a_ph, e_ph);
                chk(bad_dig == 0, "R11", "reading with comparator noise", a_dig, e_dig);
            end else begin
                chk(bad_ph == 0, "R1 R2 R5 R6", "phase timing {int,de,az,t}", a_ph, e_ph);
                chk(bad_dig == 0, ovr ? "R4" : "R3 R9", "reading {over,digits}", a_dig, e_dig);
            end
            chk(bad_done == 0, "R8", "cycle_done width mismatching clocks", bad_done, 0);
            chk(bad_seg == 0, "R10", "segment pattern mismatching clocks", bad_seg, 0);

            prev_dig = nv;
            prev_ovr = ovr;
        end

        repeat (NI * DIV + 6) @(posedge clk);
        @(negedge clk);
        chk(ph_deint, "R6", "in de-integrate before mid-cycle reset", ph_deint, 1);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check_reset();
        rst = 1'b0;

        finished = 1;
        summary();
        $finish;
    end
endmodule